// File: doc/BRIEF.md
# Subscriber Line Hook and Ring-Trip Supervisor

This block watches one subscriber line through a single loop-current comparator bit and turns it into a clean, active-low hook indication with a matching LED drive. The raw comparator level is first brought into the clock domain by a two-flop synchronizer. It is then qualified by a four-state machine: `ST_ONHOOK`, `ST_OFFPEND`, `ST_OFFHOOK` and `ST_ONPEND`. A change is reported only after the synchronized level has held steady for a whole window of millisecond ticks. The ticks come from a prescaler on the system clock. The normal window is short enough that make and break periods of pulse dialling still show up on the hook output.

A second, three-state machine drives the ring relay: `RG_IDLE`, `RG_DRIVE` and `RG_TRIPPED`. The host raises a ring request. The relay is energised (`RG_IDLE -> RG_DRIVE`) unless the line is already off hook (`RG_IDLE -> RG_TRIPPED`). While the relay is driven, off-hook qualification uses a much longer window, so that ringing current cannot be mistaken for a lifted handset. When off hook is confirmed during ringing, the machine goes `RG_DRIVE -> RG_TRIPPED` and drops the relay on the same edge. It stays tripped until the host withdraws the request (`RG_TRIPPED -> RG_IDLE`). Withdrawing the request while driving gives `RG_DRIVE -> RG_IDLE`.

After any release of the relay, a blanking interval follows. During it the `ST_ONHOOK -> ST_OFFPEND` transition is suppressed, and a pending candidate goes back `ST_OFFPEND -> ST_ONHOOK`. This keeps the switch-out transient from being reported. The remaining transitions are these. `ST_OFFPEND -> ST_OFFHOOK` happens on the tick that completes the window. `ST_OFFHOOK -> ST_ONPEND` happens when loop current disappears. `ST_ONPEND -> ST_OFFHOOK` happens when it returns early. `ST_ONPEND -> ST_ONHOOK` happens on the tick that completes the normal window.

Top module: `line_sup_top`

## Requirements
- R1: While reset is asserted, `hook_n_o` and `led_n_o` are 1 (on hook) and `ring_relay_o` is 0.
- R2: `led_n_o` carries the same value as `hook_n_o` on every cycle, so it is also low (0) when off hook.
- R3: Outside ringing, `loop_det_i` = 1 (loop current) must hold for HOOK_MS ticks, counted after the two-flop synchronizer, before `hook_n_o` goes to 0. A shorter burst leaves `hook_n_o` at 1. `hook_n_o` changes only on an edge where a millisecond tick is present.
- R4: While off hook, `loop_det_i` = 0 must hold for HOOK_MS ticks before `hook_n_o` returns to 1. A shorter break leaves it at 0.
- R5: Dial pulses whose break and make periods each exceed HOOK_MS toggle `hook_n_o` once per period: one rising edge per break.
- R6: `ring_relay_o` follows `ring_req_i` one clock later while no trip is latched. It is never 1 unless `ring_req_i` was 1 on the previous cycle.
- R7: While the relay is driven, loop current shorter than TRIP_MS ticks is not reported. Loop current held for TRIP_MS ticks sets `hook_n_o` to 0 and clears `ring_relay_o` on the same edge, and the two are never 1 and 0 respectively on the same cycle.
- R8: A latched trip keeps `ring_relay_o` at 0 for as long as `ring_req_i` stays 1. A request raised while already off hook never energises the relay. Withdrawing the request clears the latch, so that a later request on an on-hook line drives the relay again.
- R9: For BLANK_MS ticks after `ring_relay_o` falls, off-hook qualification cannot start and `hook_n_o` cannot fall. An off-hook that starts at the release is therefore reported after BLANK_MS plus HOOK_MS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loop_det_i | input | 1 | Raw loop-current comparator, 1 = current flowing |
| ring_req_i | input | 1 | Host request to apply ringing |
| hook_n_o | output | 1 | Qualified hook state, 0 = off hook |
| led_n_o | output | 1 | LED drive, 0 = off hook (lit) |
| ring_relay_o | output | 1 | Ring relay driver enable |

## Verification
Several rules are checked by properties on every cycle. The hook output moves only on tick edges, and each hook edge agrees with the comparator level three clocks earlier. The relay is never on without a prior request, never on while the line reads off hook, and the hook output cannot fall during blanking. The window lengths need the bench's scenarios, and so do the dial-pulse count, the difference between the short and long windows under ringing bursts, the latch persistence across repeated requests and the delayed report after release. In those scenarios a behavioural model is compared with the outputs on every clock.

// File: rtl/line_sup_pkg.sv
package line_sup_pkg;

    typedef enum logic [1:0] {
        ST_ONHOOK,
        ST_OFFPEND,
        ST_OFFHOOK,
        ST_ONPEND
    } hook_st_e;

    typedef enum logic [1:0] {
        RG_IDLE,
        RG_DRIVE,
        RG_TRIPPED
    } ring_st_e;

endpackage

// File: rtl/line_sup_sync.sv
module line_sup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe_q[g] <= 1'b0;
                    else        pipe_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe_q[g] <= 1'b0;
                    else        pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/line_sup_tick.sv
module line_sup_tick #(
    parameter int CLK_PER_MS = 200000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int TW = $clog2(CLK_PER_MS + 1);
    localparam logic [TW-1:0] LAST = TW'(CLK_PER_MS - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/line_sup_qual.sv
module line_sup_qual
    import line_sup_pkg::*;
#(
    parameter int HOOK_MS = 20,
    parameter int TRIP_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    input  logic tick_i,
    input  logic ring_on_i,
    input  logic blank_on_i,
    output logic off_now_o,
    output logic off_next_o
);
    localparam int MAXW = (HOOK_MS > TRIP_MS) ? HOOK_MS : TRIP_MS;
    localparam int CW   = $clog2(MAXW + 1);
    localparam logic [CW-1:0] HOOK_LIM = CW'(HOOK_MS - 1);
    localparam logic [CW-1:0] TRIP_LIM = CW'(TRIP_MS - 1);

    hook_st_e      state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] off_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ONHOOK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        off_lim = ring_on_i ? TRIP_LIM : HOOK_LIM;
        unique case (state_q)
            ST_ONHOOK: begin
                if (smp_i && !blank_on_i) begin
                    state_d = ST_OFFPEND;
                    cnt_d   = '0;
                end
            end
            ST_OFFPEND: begin
                if (!smp_i || blank_on_i) begin
                    state_d = ST_ONHOOK;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    if (cnt_q >= off_lim) begin
                        state_d = ST_OFFHOOK;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_OFFHOOK: begin
                if (!smp_i) begin
                    state_d = ST_ONPEND;
                    cnt_d   = '0;
                end
            end
            ST_ONPEND: begin
                if (smp_i) begin
                    state_d = ST_OFFHOOK;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    if (cnt_q >= HOOK_LIM) begin
                        state_d = ST_ONHOOK;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
        endcase
    end

    always_comb begin
        off_now_o  = (state_q == ST_OFFHOOK) || (state_q == ST_ONPEND);
        off_next_o = (state_d == ST_OFFHOOK) || (state_d == ST_ONPEND);
    end
endmodule

// File: rtl/line_sup_ring.sv
module line_sup_ring
    import line_sup_pkg::*;
#(
    parameter int BLANK_MS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_req_i,
    input  logic off_next_i,
    input  logic tick_i,
    output logic relay_o,
    output logic blank_on_o
);
    localparam int BW = $clog2(BLANK_MS + 2);
    localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_MS);

    ring_st_e      state_q, state_d;
    logic [BW-1:0] blank_q, blank_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RG_IDLE;
            blank_q <= '0;
        end else begin
            state_q <= state_d;
            blank_q <= blank_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RG_IDLE: begin
                if (ring_req_i) state_d = off_next_i ? RG_TRIPPED : RG_DRIVE;
            end
            RG_DRIVE: begin
                if (!ring_req_i)     state_d = RG_IDLE;
                else if (off_next_i) state_d = RG_TRIPPED;
            end
            RG_TRIPPED: begin
                if (!ring_req_i) state_d = RG_IDLE;
            end
            default: state_d = RG_IDLE;
        endcase
    end

    always_comb begin
        blank_d = blank_q;
        if (state_q == RG_DRIVE && state_d != RG_DRIVE) blank_d = BLANK_LD;
        else if (tick_i && blank_q != '0)              blank_d = blank_q - 1'b1;
    end

    always_comb begin
        relay_o    = (state_q == RG_DRIVE);
        blank_on_o = (blank_q != '0);
    end
endmodule

// File: rtl/line_sup_top.sv
module line_sup_top #(
    parameter int CLK_PER_MS = 200000,
    parameter int HOOK_MS    = 20,
    parameter int TRIP_MS    = 100,
    parameter int BLANK_MS   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_det_i,
    input  logic ring_req_i,
    output logic hook_n_o,
    output logic led_n_o,
    output logic ring_relay_o
);
    logic smp;
    logic tick;
    logic off_now;
    logic off_next;
    logic blank_on;

    line_sup_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (loop_det_i),
        .q_o   (smp)
    );

    line_sup_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    line_sup_qual #(.HOOK_MS(HOOK_MS), .TRIP_MS(TRIP_MS)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_i      (smp),
        .tick_i     (tick),
        .ring_on_i  (ring_relay_o),
        .blank_on_i (blank_on),
        .off_now_o  (off_now),
        .off_next_o (off_next)
    );

    line_sup_ring #(.BLANK_MS(BLANK_MS)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_req_i (ring_req_i),
        .off_next_i (off_next),
        .tick_i     (tick),
        .relay_o    (ring_relay_o),
        .blank_on_o (blank_on)
    );

    assign hook_n_o = !off_now;
    assign led_n_o  = !off_now;
endmodule

// File: rtl/line_sup_chk.sv
module line_sup_chk (
    input logic clk,
    input logic rst_n,
    input logic loop_det_i,
    input logic ring_req_i,
    input logic hook_n_o,
    input logic ring_relay_o,
    input logic tick,
    input logic blank_on
);
    // R3: hook output moves only on an edge carrying a millisecond tick
    assert_hook_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hook_n_o) |-> $past(tick));

    // R3: going off hook agrees with the comparator level seen through the synchronizer
    assert_off_follows_det_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hook_n_o) |-> $past(loop_det_i, 3));

    // R4: going on hook agrees with the comparator level seen through the synchronizer
    assert_on_follows_det_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hook_n_o) |-> !$past(loop_det_i, 3));

    // R6: relay never energised without a request on the previous cycle
    assert_relay_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ring_relay_o |-> $past(ring_req_i));

    // R7: relay and off-hook indication never coexist
    assert_no_ring_offhook_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ring_relay_o && !hook_n_o));

    // R9: no off-hook report may start while blanking
    assert_quiet_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_on && hook_n_o) |=> hook_n_o);
endmodule

bind line_sup_top line_sup_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .loop_det_i   (loop_det_i),
    .ring_req_i   (ring_req_i),
    .hook_n_o     (hook_n_o),
    .ring_relay_o (ring_relay_o),
    .tick         (tick),
    .blank_on     (blank_on)
);

// File: tb/line_sup_top_test.sv
`timescale 1ns/1ps
module line_sup_top_test;
    localparam int CPM   = 4;
    localparam int HOOK  = 20;
    localparam int TRIP  = 100;
    localparam int BLANK = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loop_det = 1'b0;
    logic ring_req = 1'b0;
    logic hook_n, led_n, relay;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;
    bit cnt_rises = 1'b0;
    int rises = 0;
    logic prev_hook = 1'b1;

    always #2.5 clk = ~clk;

    line_sup_top #(.CLK_PER_MS(CPM), .HOOK_MS(HOOK), .TRIP_MS(TRIP), .BLANK_MS(BLANK)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .loop_det_i   (loop_det),
        .ring_req_i   (ring_req),
        .hook_n_o     (hook_n),
        .led_n_o      (led_n),
        .ring_relay_o (relay)
    );

    // behavioural reference model
    int  m_tc;
    int  m_elapsed;
    int  m_blank;
    int  m_ring;          // 0 idle, 1 driving, 2 tripped
    bit  m_off;
    bit  m_sq[$];

    always @(posedge clk) begin
        bit smp, tk, drive, blk;
        int need;
        if (!rst_n) begin
            m_tc = 0; m_elapsed = -1; m_blank = 0; m_ring = 0; m_off = 1'b0;
            m_sq = '{1'b0, 1'b0};
        end else begin
            smp   = m_sq[0];
            tk    = (m_tc == CPM - 1);
            drive = (m_ring == 1);
            blk   = (m_blank > 0);
            void'(m_sq.pop_front());
            m_sq.push_back(loop_det);
            m_tc = tk ? 0 : m_tc + 1;
            if (smp == m_off || (!m_off && blk)) m_elapsed = -1;
            else if (m_elapsed < 0) m_elapsed = 0;
            else if (tk) begin
                m_elapsed++;
                need = m_off ? HOOK : (drive ? TRIP : HOOK);
                if (m_elapsed >= need) begin
                    m_off = !m_off;
                    m_elapsed = -1;
                end
            end
            if (!ring_req) m_ring = 0;
            else if (m_off) m_ring = (m_ring == 1 || m_ring == 2) ? 2 : 2;
            else if (m_ring == 0) m_ring = 1;
            if (drive && m_ring != 1) m_blank = BLANK;
            else if (tk && m_blank > 0) m_blank--;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(cur_req, hook_n, !m_off);
            chk("R2", led_n, hook_n);
            chk(cur_req, relay, m_ring == 1);
        end
        if (cnt_rises && prev_hook === 1'b0 && hook_n === 1'b1) rises++;
        prev_hook = hook_n;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        step(5);
        chk("R1", hook_n, 1'b1);
        chk("R1", led_n, 1'b1);
        chk("R1", relay, 1'b0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R3 short burst then a qualified off hook
        cur_req = "R3";
        loop_det = 1'b1; step(40);
        loop_det = 1'b0; step(100);
        chk("R3", hook_n, 1'b1);
        loop_det = 1'b1; step(120);
        chk("R3", hook_n, 1'b0);
        chk("R2", led_n, 1'b0);

        // R4 short break then a qualified on hook
        cur_req = "R4";
        loop_det = 1'b0; step(40);
        chk("R4", hook_n, 1'b0);
        loop_det = 1'b1; step(10);
        loop_det = 1'b0; step(120);
        chk("R4", hook_n, 1'b1);

        // R5 three dial pulses
        cur_req = "R5";
        loop_det = 1'b1; step(120);
        cnt_rises = 1'b1;
        for (int p = 0; p < 3; p++) begin
            loop_det = 1'b0; step(240);
            loop_det = 1'b1; step(160);
        end
        cnt_rises = 1'b0;
        chk_int("R5", rises, 3);
        chk("R5", hook_n, 1'b0);
        loop_det = 1'b0; step(200);
        chk("R5", hook_n, 1'b1);

        // R6 relay follows request
        cur_req = "R6";
        ring_req = 1'b1; step(1);
        chk("R6", relay, 1'b1);

        // R7 ringing bursts rejected, sustained loop trips ring
        cur_req = "R7";
        loop_det = 1'b1; step(200);
        loop_det = 1'b0; step(40);
        loop_det = 1'b1; step(200);
        chk("R7", hook_n, 1'b1);
        chk("R7", relay, 1'b1);
        loop_det = 1'b0; step(20);
        loop_det = 1'b1; step(480);
        chk("R7", hook_n, 1'b0);
        chk("R7", relay, 1'b0);

        // R8 trip latch behaviour
        cur_req = "R8";
        step(100);
        chk("R8", relay, 1'b0);
        ring_req = 1'b0; step(5);
        ring_req = 1'b1; step(5);
        chk("R8", relay, 1'b0);
        ring_req = 1'b0;
        loop_det = 1'b0; step(120);
        chk("R8", hook_n, 1'b1);
        ring_req = 1'b1; step(2);
        chk("R8", relay, 1'b1);

        // R9 blanking after release delays off-hook qualification
        cur_req = "R9";
        ring_req = 1'b0;
        loop_det = 1'b1; step(100);
        chk("R9", hook_n, 1'b1);
        step(60);
        chk("R9", hook_n, 1'b0);
        loop_det = 1'b0; step(120);
        chk("R9", hook_n, 1'b1);

        finish_run();
    end
endmodule